// File: doc/BRIEF.md
# PHY link speed resolver

This block turns the status words of an Ethernet PHY into the speed and duplex controls of a MAC. A single `start` pulse launches a short sequence of register reads over a plain request/acknowledge management port. Each read is held on the port until the management side acknowledges it with the read data. When gigabit support is compiled in, the 1000BASE-T status word is read first and the basic status word second. Otherwise only the basic status word is read.

Once the last read completes, the block first checks the link bit. If the link is up, it picks a single operating mode from a fixed priority list. It then drives three registered mode controls: gigabit mode, fast (100 Mb/s) mode and full duplex. Every resolution ends with a one-cycle `done` pulse and a two-bit result code. The code tells the caller whether the mode was applied, the link was down, or no ability bit matched. The priority list is deliberately uneven: 10 Mb/s full duplex is chosen ahead of 100 Mb/s half duplex.

Top module: `lnk_speed_resolver`

## Requirements
- R1: A `start` seen while idle issues management reads. With GIGA_EN=1, register 10 is read first and then register 1. Each request keeps `mgmt_req` high and `mgmt_reg` stable until the cycle `mgmt_ack` is high.
- R2: If bit 2 (link) of register 1 is 0, the result is 1 (down) and all three mode outputs keep their previous values.
- R3: With the link up and bit 11 of register 10 set (partner 1000 full), the outputs become giga=1, fast=0, full=1, whatever the other bits.
- R4: With the link up, bit 11 of register 10 clear and bit 10 set (partner 1000 half), the outputs become giga=1, fast=0, full=0.
- R5: After the two gigabit cases, register 1 ability bits are tried in this order, and the first set bit wins: bit 14 (100 full), bit 12 (10 full), bit 13 (100 half), bit 11 (10 half).
- R6: The chosen mode replaces all three outputs. 100 full gives fast=1, full=1. 10 full gives full=1 only. 100 half gives fast=1 only. 10 half clears all three. Giga is cleared in every non-gigabit case.
- R7: With GIGA_EN=0, register 10 is never requested and its bits have no effect on the outputs.
- R8: If the link is up but none of the ability bits used is set, the result is 2 (no match) and the outputs keep their previous values.
- R9: `done` is high for exactly one cycle, the cycle after the acknowledge of the final read. `result` (0 = mode applied) and the mode outputs take their new values in that same cycle.
- R10: `busy` is high from the cycle after an accepted `start` until the final acknowledge. A `start` seen while busy is ignored: it causes no extra reads and no extra `done`.
- R11: After reset, all mode outputs, `busy`, `done`, `mgmt_req` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a resolution (ignored while busy) |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle end-of-resolution pulse |
| result | output | 2 | 0 applied, 1 link down, 2 no match |
| mgmt_req | output | 1 | Read request to management port |
| mgmt_reg | output | REG_W | Register number being read |
| mgmt_ack | input | 1 | Read complete, data valid |
| mgmt_rdata | input | DAT_W | Read data |
| giga_mode | output | 1 | MAC gigabit mode |
| fast_mode | output | 1 | MAC 100 Mb/s mode |
| full_duplex | output | 1 | MAC full duplex |

## Verification
The status words applied include one where every ability bit is set, so that the top gigabit case must win. Others hold both gigabit bits, leave out the higher-priority bit one step at a time, set 10 full together with 100 half to expose the uneven ordering, or keep the ability bits but drop the link bit. A link-up word with no ability bits tells the no-match path apart from the down path: both must leave the earlier outputs in place. A gigabit-only word paired with an empty basic word shows that the gigabit cases need no basic ability bit. A second instance built without gigabit support receives the same partner words, to show that register 10 is never read and that its bits change nothing.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    localparam int unsigned LNK_REG_W = 5;
    localparam int unsigned LNK_DAT_W = 16;

    // Management register numbers
    localparam int unsigned REG_BASIC_STAT = 1;
    localparam int unsigned REG_GIG_STAT   = 10;

    // Field positions inside the status words
    localparam int unsigned BIT_LINK   = 2;
    localparam int unsigned BIT_10HD   = 11;
    localparam int unsigned BIT_10FD   = 12;
    localparam int unsigned BIT_100HD  = 13;
    localparam int unsigned BIT_100FD  = 14;
    localparam int unsigned BIT_G_HD   = 10;
    localparam int unsigned BIT_G_FD   = 11;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_DOWN    = 2'd1,
        RES_NOMATCH = 2'd2
    } lnk_res_e;

    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_RD_GIG   = 2'd1,
        SQ_RD_BASIC = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic giga;
        logic fast;
        logic full;
    } lnk_mode_t;

    typedef struct packed {
        logic link;
        logic a100fd;
        logic a100hd;
        logic a10fd;
        logic a10hd;
        logic g1000fd;
        logic g1000hd;
    } lnk_abil_t;

endpackage

// File: rtl/lnk_mgmt_seq.sv
module lnk_mgmt_seq
    import lnk_pkg::*;
#(
    parameter bit          GIGA_EN = 1'b1,
    parameter int unsigned REG_W   = LNK_REG_W,
    parameter int unsigned DAT_W   = LNK_DAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mgmt_ack,
    input  logic [DAT_W-1:0] mgmt_rdata,
    output logic             mgmt_req,
    output logic [REG_W-1:0] mgmt_reg,
    output logic             busy,
    output logic             fin,
    output lnk_abil_t        abil
);

    typedef struct packed {
        sq_state_e st;
        logic      g_fd;
        logic      g_hd;
    } seq_t;

    seq_t      seq_d, seq_q;
    sq_state_e first_st;
    logic      unused_rdata;

    assign unused_rdata = ^mgmt_rdata;

    // Parameter picks where a run begins
    if (GIGA_EN) begin : g_gig_first
        assign first_st = SQ_RD_GIG;
    end else begin : g_basic_only
        assign first_st = SQ_RD_BASIC;
    end

    always_comb begin
        seq_d = seq_q;
        fin   = 1'b0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    seq_d.g_fd = 1'b0;
                    seq_d.g_hd = 1'b0;
                    seq_d.st   = first_st;
                end
            end
            SQ_RD_GIG: begin
                if (mgmt_ack) begin
                    seq_d.g_fd = mgmt_rdata[BIT_G_FD];
                    seq_d.g_hd = mgmt_rdata[BIT_G_HD];
                    seq_d.st   = SQ_RD_BASIC;
                end
            end
            SQ_RD_BASIC: begin
                if (mgmt_ack) begin
                    fin      = 1'b1;
                    seq_d.st = SQ_IDLE;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, g_fd: 1'b0, g_hd: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st != SQ_IDLE);
    assign mgmt_req = busy;
    assign mgmt_reg = (seq_q.st == SQ_RD_GIG) ? REG_W'(REG_GIG_STAT)
                                              : REG_W'(REG_BASIC_STAT);

    // Basic word fields are used straight off the bus in the finishing cycle
    always_comb begin
        abil.link    = mgmt_rdata[BIT_LINK];
        abil.a100fd  = mgmt_rdata[BIT_100FD];
        abil.a100hd  = mgmt_rdata[BIT_100HD];
        abil.a10fd   = mgmt_rdata[BIT_10FD];
        abil.a10hd   = mgmt_rdata[BIT_10HD];
        abil.g1000fd = seq_q.g_fd;
        abil.g1000hd = seq_q.g_hd;
    end

endmodule

// File: rtl/lnk_mode_pick.sv
module lnk_mode_pick
    import lnk_pkg::*;
#(
    parameter bit GIGA_EN = 1'b1
) (
    input  lnk_abil_t abil,
    output logic      match,
    output lnk_mode_t mode
);

    logic g_fd, g_hd;

    assign g_fd = GIGA_EN && abil.g1000fd;
    assign g_hd = GIGA_EN && abil.g1000hd;

    // Fixed priority; each branch writes the whole mode word
    always_comb begin
        mode  = '0;
        match = 1'b1;
        if (g_fd) begin
            mode.giga = 1'b1;
            mode.full = 1'b1;
        end else if (g_hd) begin
            mode.giga = 1'b1;
        end else if (abil.a100fd) begin
            mode.fast = 1'b1;
            mode.full = 1'b1;
        end else if (abil.a10fd) begin
            mode.full = 1'b1;
        end else if (abil.a100hd) begin
            mode.fast = 1'b1;
        end else if (abil.a10hd) begin
            mode = '0;
        end else begin
            match = 1'b0;
        end
    end

endmodule

// File: rtl/lnk_speed_resolver.sv
module lnk_speed_resolver
    import lnk_pkg::*;
#(
    parameter bit          GIGA_EN = 1'b1,
    parameter int unsigned REG_W   = LNK_REG_W,
    parameter int unsigned DAT_W   = LNK_DAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result,
    output logic             mgmt_req,
    output logic [REG_W-1:0] mgmt_reg,
    input  logic             mgmt_ack,
    input  logic [DAT_W-1:0] mgmt_rdata,
    output logic             giga_mode,
    output logic             fast_mode,
    output logic             full_duplex
);

    typedef struct packed {
        lnk_mode_t mode;
        logic      done;
        lnk_res_e  res;
    } out_t;

    out_t      out_d, out_q;
    logic      fin;
    logic      match;
    lnk_abil_t abil;
    lnk_mode_t pick;

    lnk_mgmt_seq #(
        .GIGA_EN (GIGA_EN),
        .REG_W   (REG_W),
        .DAT_W   (DAT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mgmt_ack   (mgmt_ack),
        .mgmt_rdata (mgmt_rdata),
        .mgmt_req   (mgmt_req),
        .mgmt_reg   (mgmt_reg),
        .busy       (busy),
        .fin        (fin),
        .abil       (abil)
    );

    lnk_mode_pick #(
        .GIGA_EN (GIGA_EN)
    ) u_pick (
        .abil  (abil),
        .match (match),
        .mode  (pick)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = 1'b0;
        if (fin) begin
            out_d.done = 1'b1;
            if (!abil.link) begin
                out_d.res = RES_DOWN;
            end else if (!match) begin
                out_d.res = RES_NOMATCH;
            end else begin
                out_d.res  = RES_OK;
                out_d.mode = pick;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{mode: '0, done: 1'b0, res: RES_OK};
        end else begin
            out_q <= out_d;
        end
    end

    assign done        = out_q.done;
    assign result      = out_q.res;
    assign giga_mode   = out_q.mode.giga;
    assign fast_mode   = out_q.mode.fast;
    assign full_duplex = out_q.mode.full;

endmodule

// File: rtl/lnk_speed_resolver_chk.sv
module lnk_speed_resolver_chk #(
    parameter bit          GIGA_EN = 1'b1,
    parameter int unsigned REG_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [1:0]       result,
    input logic             mgmt_req,
    input logic [REG_W-1:0] mgmt_reg,
    input logic             mgmt_ack,
    input logic             giga_mode,
    input logic             fast_mode,
    input logic             full_duplex
);

    p_req_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req && !mgmt_ack |=> mgmt_req && $stable(mgmt_reg));

    p_down_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == 2'd1 |-> $stable({giga_mode, fast_mode, full_duplex}));

    p_giga_not_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == 2'd0 && giga_mode |-> !fast_mode);

    p_basic_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !GIGA_EN && mgmt_req |-> mgmt_reg == REG_W'(1));

    p_nomatch_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == 2'd2 |-> $stable({giga_mode, fast_mode, full_duplex}));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mgmt_ack |=> busy);

endmodule

bind lnk_speed_resolver lnk_speed_resolver_chk #(
    .GIGA_EN (GIGA_EN),
    .REG_W   (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .mgmt_req    (mgmt_req),
    .mgmt_reg    (mgmt_reg),
    .mgmt_ack    (mgmt_ack),
    .giga_mode   (giga_mode),
    .fast_mode   (fast_mode),
    .full_duplex (full_duplex)
);

// File: tb/sim_lnk_speed_resolver.sv
`timescale 1ns/1ps

module sim_mgmt_responder (
    input  logic        clk,
    input  logic        clr,
    input  logic        req,
    input  logic [4:0]  regn,
    input  logic [15:0] basic_val,
    input  logic [15:0] gig_val,
    output logic        ack,
    output logic [15:0] rdata,
    output int          reads,
    output int          gig_reads,
    output logic [4:0]  first_reg
);
    int wait_cnt;

    initial begin
        ack = 0; rdata = 0; reads = 0; gig_reads = 0; first_reg = 5'h1f; wait_cnt = 0;
    end

    always @(negedge clk) begin
        if (clr) begin
            ack = 0; reads = 0; gig_reads = 0; first_reg = 5'h1f; wait_cnt = 0;
        end else if (ack) begin
            ack = 0; wait_cnt = 0;
        end else if (req) begin
            if (wait_cnt == 2) begin
                ack   = 1;
                rdata = (regn == 5'd10) ? gig_val : ((regn == 5'd1) ? basic_val : 16'hffff);
                if (reads == 0) first_reg = regn;
                reads++;
                if (regn == 5'd10) gig_reads++;
            end else begin
                wait_cnt++;
            end
        end
    end
endmodule

module sim_lnk_speed_resolver;

    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // instance u0: gigabit enabled
    logic        start0 = 0, clr0 = 0;
    logic [15:0] bv0 = 0, gv0 = 0;
    logic        busy0, done0, req0, ack0, gm0, fm0, fd0;
    logic [1:0]  res0;
    logic [4:0]  reg0, first0;
    logic [15:0] rd0;
    int          reads0, greads0;

    // instance u1: gigabit disabled
    logic        start1 = 0, clr1 = 0;
    logic [15:0] bv1 = 0, gv1 = 0;
    logic        busy1, done1, req1, ack1, gm1, fm1, fd1;
    logic [1:0]  res1;
    logic [4:0]  reg1, first1;
    logic [15:0] rd1;
    int          reads1, greads1;

    lnk_speed_resolver #(.GIGA_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start0), .busy(busy0), .done(done0),
        .result(res0), .mgmt_req(req0), .mgmt_reg(reg0), .mgmt_ack(ack0),
        .mgmt_rdata(rd0), .giga_mode(gm0), .fast_mode(fm0), .full_duplex(fd0));

    sim_mgmt_responder r0 (
        .clk(clk), .clr(clr0), .req(req0), .regn(reg0), .basic_val(bv0), .gig_val(gv0),
        .ack(ack0), .rdata(rd0), .reads(reads0), .gig_reads(greads0), .first_reg(first0));

    lnk_speed_resolver #(.GIGA_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .busy(busy1), .done(done1),
        .result(res1), .mgmt_req(req1), .mgmt_reg(reg1), .mgmt_ack(ack1),
        .mgmt_rdata(rd1), .giga_mode(gm1), .fast_mode(fm1), .full_duplex(fd1));

    sim_mgmt_responder r1 (
        .clk(clk), .clr(clr1), .req(req1), .regn(reg1), .basic_val(bv1), .gig_val(gv1),
        .ack(ack1), .rdata(rd1), .reads(reads1), .gig_reads(greads1), .first_reg(first1));

    // {basic word, gigabit word, expected result, expected {giga,fast,full}}
    localparam logic [36:0] VECS [0:11] = '{
        {16'h7804, 16'h0800, 2'd0, 3'b101},  // R3 all abilities, 1000 full wins
        {16'h7804, 16'h0C00, 2'd0, 3'b101},  // R3 both gigabit bits
        {16'h7804, 16'h0400, 2'd0, 3'b100},  // R4 1000 half
        {16'h7804, 16'h0000, 2'd0, 3'b011},  // R5 100 full first of basic
        {16'h3804, 16'h0000, 2'd0, 3'b001},  // R5 10 full ahead of 100 half
        {16'h2804, 16'h0000, 2'd0, 3'b010},  // R5 100 half ahead of 10 half
        {16'h0804, 16'h0000, 2'd0, 3'b000},  // R6 10 half clears all
        {16'h4004, 16'h0000, 2'd0, 3'b011},  // R6 100 full alone
        {16'h7800, 16'h0800, 2'd1, 3'b011},  // R2 link down keeps outputs
        {16'h0004, 16'h0000, 2'd2, 3'b011},  // R8 no ability keeps outputs
        {16'h0004, 16'h0400, 2'd0, 3'b100},  // R4 gigabit needs no basic ability
        {16'h1004, 16'h0000, 2'd0, 3'b001}   // R6 10 full clears giga
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic run0(input logic [15:0] b, input logic [15:0] g, output int lat);
        bv0 = b; gv0 = g; clr0 = 1;
        @(negedge clk); clr0 = 0; start0 = 1;
        @(negedge clk); start0 = 0;
        lat = -1;
        for (int k = 0; k < 60; k++) begin
            if (done0) begin lat = k; break; end
            @(negedge clk);
        end
    endtask

    task automatic run1(input logic [15:0] b, input logic [15:0] g, output int lat);
        bv1 = b; gv1 = g; clr1 = 1;
        @(negedge clk); clr1 = 0; start1 = 1;
        @(negedge clk); start1 = 0;
        lat = -1;
        for (int k = 0; k < 60; k++) begin
            if (done1) begin lat = k; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        int dones;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({gm0, fm0, fd0} == 3'b000, "R11", "modes in reset", {gm0, fm0, fd0}, 0);
        chk(!busy0 && !done0 && !req0, "R11", "busy/done/req in reset", {busy0, done0, req0}, 0);
        chk(res0 == 2'd0, "R11", "result in reset", res0, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy0 && !req0 && {gm1, fm1, fd1} == 3'b000, "R11", "idle after reset",
            {busy0, req0}, 0);

        for (int i = 0; i < 12; i++) begin
            run0(VECS[i][36:21], VECS[i][20:5], lat);
            chk(lat >= 0, "R9", $sformatf("vec %0d done seen", i), lat, 7);
            chk(res0 == VECS[i][4:3], "R2/R3/R8", $sformatf("vec %0d result", i),
                res0, VECS[i][4:3]);
            chk({gm0, fm0, fd0} == VECS[i][2:0], "R3/R4/R5/R6", $sformatf("vec %0d modes", i),
                {gm0, fm0, fd0}, VECS[i][2:0]);
            @(negedge clk);
            chk(!done0, "R9", $sformatf("vec %0d done width", i), done0, 0);
        end

        // R1 read order and count, R9 exact latency with gigabit
        run0(16'h4004, 16'h0000, lat);
        chk(first0 == 5'd10, "R1", "first register read", first0, 10);
        chk(reads0 == 2 && greads0 == 1, "R1", "reads per run", reads0, 2);
        chk(lat == 7, "R9", "done cycle after final ack", lat, 7);
        @(negedge clk);

        // R10 start while busy ignored
        bv0 = 16'h0804; gv0 = 16'h0000; clr0 = 1;
        @(negedge clk); clr0 = 0; start0 = 1;
        @(negedge clk); start0 = 0;
        @(negedge clk); start0 = 1;
        @(negedge clk); start0 = 0;
        chk(busy0, "R10", "busy during run", busy0, 1);
        dones = 0;
        for (int k = 0; k < 30; k++) begin
            if (done0) dones++;
            @(negedge clk);
        end
        chk(dones == 1, "R10", "done count with extra start", dones, 1);
        chk(reads0 == 2, "R10", "read count with extra start", reads0, 2);
        chk({gm0, fm0, fd0} == 3'b000, "R10", "modes after run", {gm0, fm0, fd0}, 0);

        // R7 gigabit disabled instance
        run1(16'h7804, 16'h0800, lat);
        chk(lat == 3, "R7", "basic-only done latency", lat, 3);
        chk(res1 == 2'd0 && {gm1, fm1, fd1} == 3'b011, "R7", "gig bits ignored",
            {gm1, fm1, fd1}, 3);
        chk(greads1 == 0 && reads1 == 1 && first1 == 5'd1, "R7", "register 10 never read",
            greads1, 0);
        @(negedge clk);
        run1(16'h0004, 16'h0C00, lat);
        chk(res1 == 2'd2, "R7", "gig-only partner gives no match", res1, 2);
        chk({gm1, fm1, fd1} == 3'b011, "R8", "outputs kept on no match", {gm1, fm1, fd1}, 3);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule